// File: doc/BRIEF.md
# Add, Reverse-Subtract and Compare Unit

This block is the integer arithmetic slice of a 32-bit datapath. It takes two operands and an operation code, and it returns its result in the same cycle. The operations are addition, reverse subtraction (the second operand minus the first), signed and unsigned compare, and a byte-pattern search. The carry flag is the only state. It sits in a register inside the block, can be chained into later additions and subtractions, and is shown on a status vector at two bit positions.

The compare operations produce the difference `b - a`. When the operands' signs differ, the top bit is replaced so that the sign of the result alone gives the ordering. The pattern search reports the first byte lane, counted from the most significant end, where the two operands hold the same byte.

Top module: `arith_cmp_unit`

## Requirements
- R1: With `op_sel` = 0 (add), `result` = `opd_a + opd_b + cin` modulo 2^32. Here `cin` is the stored carry flag when `use_cy` = 1 and 0 when `use_cy` = 0.
- R2: With `op_sel` = 1 (reverse subtract), `result` = `opd_b + ~opd_a + cin` modulo 2^32. Here `cin` is the stored carry flag when `use_cy` = 1 and 1 when `use_cy` = 0.
- R3: The carry-out is bit 32 of the 33-bit sum, so it is correct when `opd_b` is all ones and `cin` = 1. For add or reverse subtract with `op_en` = 1 and `keep_cy` = 0, `cy_wr` is 1, `cy_next` shows the carry-out, and `cy_flag` takes that value at the next rising edge.
- R4: With `keep_cy` = 1, add and reverse subtract leave `cy_flag` unchanged and hold `cy_wr` at 0.
- R5: `cy_stat` has bit 31 and bit 2 both equal to `cy_flag`; every other bit is 0.
- R6: With `op_sel` = 2 (signed compare), `result` = `opd_b - opd_a`. When bit 31 of the two operands differs, result bit 31 is replaced by bit 31 of `opd_b`.
- R7: With `op_sel` = 3 (unsigned compare), `result` = `opd_b - opd_a`. When bit 31 of the two operands differs, result bit 31 is replaced by bit 31 of `opd_a`.
- R8: With `op_sel` = 4 (pattern search), `result` is the position of the first equal byte, scanning from the most significant byte. Bits 31:24 are position 1 and bits 7:0 are position 4. The result is 0 when no byte matches.
- R9: Compare, pattern search and the unused codes 5 to 7 never write the carry flag. The unused codes give `result` = 0.
- R10: A synchronous active-low reset clears `cy_flag` to 0.
- R11: With `op_en` = 0 no operation is issued: `cy_wr` is 0 and `cy_flag` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_en | input | 1 | Operation issued this cycle |
| op_sel | input | 3 | Operation code (0 add, 1 reverse subtract, 2 signed compare, 3 unsigned compare, 4 pattern search) |
| use_cy | input | 1 | Use the stored carry as carry-in |
| keep_cy | input | 1 | Leave the carry flag untouched |
| opd_a | input | 32 | First operand |
| opd_b | input | 32 | Second operand |
| result | output | 32 | Operation result |
| cy_next | output | 1 | Carry value the flag will hold after this cycle |
| cy_wr | output | 1 | Carry flag is written at the next edge |
| cy_flag | output | 1 | Stored carry flag |
| cy_stat | output | 32 | Status view of the carry flag (bits 31 and 2) |

## Verification
The hardest case to reach is a chained carry: an addition with `use_cy` set, a stored carry of 1 and `opd_b` all ones. The bench can only produce it by first running an operation whose carry-out is 1, and then issuing the chained one. Directed sequences build that case and its reverse-subtract counterpart on purpose. Long random runs mix chaining, keep-carry and idle cycles, and some of them copy single bytes of one operand into the other, so that the pattern search finds hits at every position.

// File: rtl/acu_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the arithmetic/compare unit.
// Assumes: operation codes are fixed by the decoder that feeds op_sel.
package acu_pkg;
    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_RSUB  = 3'd1,
        OP_CMPS  = 3'd2,
        OP_CMPU  = 3'd3,
        OP_MATCH = 3'd4
    } acu_op_e;

    localparam int unsigned CY_LO_BIT = 2;
    localparam int unsigned CY_HI_BIT = 31;
endpackage

// File: rtl/acu_addsub.sv
`timescale 1ns/1ps
// Adder/reverse-subtractor with a full 33-bit sum.
// What it does: computes b + a + cin, or b + ~a + cin when sub is set.
// Assumes: cin has already been chosen by the caller.
module acu_addsub #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              cout
);
    localparam int unsigned EXT_W = DATA_W + 1;

    logic [DATA_W-1:0] a_eff;
    logic [EXT_W-1:0]  wide;

    // Select the true or inverted first operand.
    always_comb begin
        a_eff = sub ? ~a : a;
    end

    // Widened sum, so the carry-out is exact in every corner.
    always_comb begin
        wide = {1'b0, b} + {1'b0, a_eff} + EXT_W'(cin);
        sum  = wide[DATA_W-1:0];
        cout = wide[DATA_W];
    end
endmodule

// File: rtl/acu_compare.sv
`timescale 1ns/1ps
// Ordering compare: returns b - a, and repairs the sign bit when the operands'
// signs differ, so that the result's top bit gives the ordering.
// Assumes: is_unsigned selects which operand supplies the repaired bit.
module acu_compare #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              is_unsigned,
    output logic [DATA_W-1:0] diff
);
    localparam int unsigned MSB = DATA_W - 1;

    logic [DATA_W-1:0] raw;
    logic              sign_split;

    // Plain wrap-around difference.
    always_comb begin
        raw        = b + ~a + DATA_W'(1);
        sign_split = a[MSB] ^ b[MSB];
    end

    // Sign repair: take b's sign (signed) or a's sign (unsigned) on a split.
    always_comb begin
        diff = raw;
        if (sign_split) begin
            diff[MSB] = is_unsigned ? a[MSB] : b[MSB];
        end
    end
endmodule

// File: rtl/acu_bytematch.sv
`timescale 1ns/1ps
// Byte-pattern search: returns the 1-based position of the first equal byte
// lane, counted from the most significant lane, or 0 when no lane matches.
// Assumes: DATA_W is a multiple of 8.
module acu_bytematch #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned POS_W  = 3
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [POS_W-1:0]  pos
);
    localparam int unsigned LANES = DATA_W / 8;

    logic [LANES-1:0] lane_eq;

    // Lane i counts from the top: lane 0 holds the most significant byte.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_eq[i] = (a[DATA_W-1-8*i -: 8] == b[DATA_W-1-8*i -: 8]);
    end

    // Priority pick: scan from the bottom lane up, so the top-most hit wins.
    always_comb begin
        pos = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (lane_eq[i]) begin
                pos = POS_W'(i + 1);
            end
        end
    end

    // The position never exceeds the lane count.
    always_comb begin
        AST_MATCH_RANGE: assert (int'(pos) <= LANES); // R8
    end
endmodule

// File: rtl/arith_cmp_unit.sv
`timescale 1ns/1ps
// Add, reverse-subtract and compare unit with a registered carry flag.
// What it does: combinational result for five operations. The carry flag is
// updated by add/reverse subtract unless keep_cy is set, and it is shown at
// two status bit positions.
// Assumes: op_en marks an issued operation; the flag is local to this block.
module arith_cmp_unit
    import acu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_en,
    input  logic [2:0]        op_sel,
    input  logic              use_cy,
    input  logic              keep_cy,
    input  logic [DATA_W-1:0] opd_a,
    input  logic [DATA_W-1:0] opd_b,
    output logic [DATA_W-1:0] result,
    output logic              cy_next,
    output logic              cy_wr,
    output logic              cy_flag,
    output logic [31:0]       cy_stat
);
    localparam int unsigned LANES = DATA_W / 8;
    localparam int unsigned POS_W = $clog2(LANES + 1);

    logic              cy_q;
    logic              is_arith;
    logic              is_sub;
    logic              cin;
    logic [DATA_W-1:0] as_sum;
    logic              as_cout;
    logic [DATA_W-1:0] cmp_diff;
    logic [POS_W-1:0]  match_pos;

    // Decode the operation class and pick the carry-in.
    always_comb begin
        is_arith = (op_sel == OP_ADD) || (op_sel == OP_RSUB);
        is_sub   = (op_sel == OP_RSUB);
        if (use_cy) cin = cy_q;
        else        cin = is_sub;
    end

    acu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a    (opd_a),
        .b    (opd_b),
        .sub  (is_sub),
        .cin  (cin),
        .sum  (as_sum),
        .cout (as_cout)
    );

    acu_compare #(.DATA_W(DATA_W)) u_compare (
        .a           (opd_a),
        .b           (opd_b),
        .is_unsigned (op_sel == OP_CMPU),
        .diff        (cmp_diff)
    );

    acu_bytematch #(.DATA_W(DATA_W), .POS_W(POS_W)) u_match (
        .a   (opd_a),
        .b   (opd_b),
        .pos (match_pos)
    );

    // Result multiplexer; unused codes give zero.
    always_comb begin
        case (op_sel)
            OP_ADD, OP_RSUB:  result = as_sum;
            OP_CMPS, OP_CMPU: result = cmp_diff;
            OP_MATCH:         result = DATA_W'(match_pos);
            default:          result = '0;
        endcase
    end

    // Carry write decision and the value the flag will hold next.
    always_comb begin
        cy_wr   = op_en && is_arith && !keep_cy;
        cy_next = cy_wr ? as_cout : cy_q;
    end

    // Carry flag register, synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cy_q <= 1'b0;
        else        cy_q <= cy_next;
    end

    // Status view: the flag appears at two fixed bit positions.
    always_comb begin
        cy_flag            = cy_q;
        cy_stat            = '0;
        cy_stat[CY_HI_BIT] = cy_q;
        cy_stat[CY_LO_BIT] = cy_q;
    end

    AST_CY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && cy_wr) |=> (cy_flag == $past(as_cout))); // R3
    AST_CY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !cy_wr) |=> $stable(cy_flag)); // R4
    AST_NO_CY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_en || keep_cy || op_sel > 3'd1) |-> !cy_wr); // R9
    AST_STAT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(cy_stat) == (cy_flag ? 2 : 0))); // R5
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> !cy_flag); // R10
endmodule

// File: tb/arith_cmp_unit_tb.sv
`timescale 1ns/1ps
module arith_cmp_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_en = 1'b0;
    logic [2:0]  op_sel = 3'd0;
    logic        use_cy = 1'b0;
    logic        keep_cy = 1'b0;
    logic [31:0] opd_a = '0;
    logic [31:0] opd_b = '0;
    logic [31:0] result;
    logic        cy_next;
    logic        cy_wr;
    logic        cy_flag;
    logic [31:0] cy_stat;

    int n_chk = 0;
    int n_bad = 0;
    bit model_cy = 1'b0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    arith_cmp_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_sel(op_sel),
        .use_cy(use_cy), .keep_cy(keep_cy), .opd_a(opd_a), .opd_b(opd_b),
        .result(result), .cy_next(cy_next), .cy_wr(cy_wr),
        .cy_flag(cy_flag), .cy_stat(cy_stat)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    // Reference: 33-bit sum for add or reverse subtract.
    function automatic logic [32:0] ref_arith(input logic [2:0] op, input logic [31:0] a,
                                              input logic [31:0] b, input bit uc, input bit cy);
        logic [32:0] ci;
        ci = (op == 3'd1) ? (uc ? 33'(cy) : 33'd1) : (uc ? 33'(cy) : 33'd0);
        if (op == 3'd1) return {1'b0, b} + {1'b0, ~a} + ci;
        return {1'b0, b} + {1'b0, a} + ci;
    endfunction

    function automatic logic [31:0] ref_cmp(input bit uns, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] d;
        d = b - a;
        if (a[31] != b[31]) d[31] = uns ? a[31] : b[31];
        return d;
    endfunction

    function automatic logic [31:0] ref_match(input logic [31:0] a, input logic [31:0] b);
        for (int k = 0; k < 4; k++)
            if (a[31-8*k -: 8] == b[31-8*k -: 8]) return 32'(k + 1);
        return 32'd0;
    endfunction

    // Issue one operation and check result, carry control and flag afterwards.
    task automatic do_op(input bit en, input logic [2:0] op, input bit uc, input bit kc,
                         input logic [31:0] a, input logic [31:0] b);
        logic [32:0] w;
        logic [31:0] exp_res;
        bit exp_wr;
        @(negedge clk);
        op_en = en; op_sel = op; use_cy = uc; keep_cy = kc; opd_a = a; opd_b = b;
        #2;
        w = ref_arith(op, a, b, uc, model_cy);
        exp_wr = 1'b0;
        case (op)
            3'd0: begin exp_res = w[31:0]; check("R1 add result", result, exp_res); end
            3'd1: begin exp_res = w[31:0]; check("R2 rsub result", result, exp_res); end
            3'd2: check("R6 signed compare", result, ref_cmp(1'b0, a, b));
            3'd3: check("R7 unsigned compare", result, ref_cmp(1'b1, a, b));
            3'd4: check("R8 pattern search", result, ref_match(a, b));
            default: check("R9 unused code result", result, 32'd0);
        endcase
        if (en && op <= 3'd1 && !kc) begin
            exp_wr = 1'b1;
            check("R3 carry next", {31'd0, cy_next}, {31'd0, w[32]});
        end
        if (!en)          check("R11 idle no write", {31'd0, cy_wr}, {31'd0, exp_wr});
        else if (op > 3'd1) check("R9 no carry write", {31'd0, cy_wr}, {31'd0, exp_wr});
        else if (kc)      check("R4 keep carry", {31'd0, cy_wr}, {31'd0, exp_wr});
        else              check("R3 carry write", {31'd0, cy_wr}, {31'd0, exp_wr});
        if (exp_wr) model_cy = w[32];
        @(posedge clk);
        #2;
        check("R3 R4 carry flag", {31'd0, cy_flag}, {31'd0, model_cy});
        check("R5 status bits", cy_stat, model_cy ? 32'h8000_0004 : 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] ra, rb;
        logic [2:0]  rop;
        void'($urandom(32'h5EED_0A1C));
        repeat (3) @(posedge clk);
        #2;
        check("R10 reset flag", {31'd0, cy_flag}, 32'd0);
        check("R10 reset status", cy_stat, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // Directed: set carry, then chain with b all ones.
        do_op(1, 3'd0, 0, 0, 32'h0000_0001, 32'hFFFF_FFFF);   // R3 carry 1
        do_op(1, 3'd0, 1, 0, 32'h0000_0000, 32'hFFFF_FFFF);   // R1 R3 corner
        do_op(1, 3'd1, 1, 1, 32'h0000_0005, 32'h0000_0003);   // R2 R4 keep
        do_op(1, 3'd1, 0, 0, 32'h0000_0005, 32'h0000_0003);   // R2 borrow -> 0
        do_op(1, 3'd1, 1, 0, 32'h0000_0000, 32'hFFFF_FFFF);   // R2 chained cin 0
        do_op(0, 3'd0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);   // R11
        do_op(1, 3'd2, 0, 0, 32'h0000_0001, 32'h8000_0000);   // R6
        do_op(1, 3'd3, 0, 0, 32'h0000_0001, 32'h8000_0000);   // R7
        do_op(1, 3'd2, 0, 0, 32'h8000_0000, 32'h7FFF_FFFF);   // R6
        do_op(1, 3'd4, 0, 0, 32'h1122_3344, 32'h0022_3300);   // R8 -> 2
        do_op(1, 3'd4, 0, 0, 32'h1122_3344, 32'h0000_0044);   // R8 -> 4
        do_op(1, 3'd4, 0, 0, 32'h1122_3344, 32'h5566_7788);   // R8 -> 0
        do_op(1, 3'd4, 0, 0, 32'hAB00_0000, 32'hAB11_2233);   // R8 -> 1
        do_op(1, 3'd6, 0, 0, 32'h1234_5678, 32'h9ABC_DEF0);   // R9 unused

        // Random mix.
        for (int i = 0; i < 1500; i++) begin
            ra = $urandom; rb = $urandom;
            rop = 3'($urandom % 8);
            if ($urandom % 4 == 0) rb[8*($urandom%4) +: 8] = ra[8*($urandom%4) +: 8];
            if ($urandom % 4 == 0) rb[31-8*($urandom%4) -: 8] = ra[31-8*($urandom%4) -: 8];
            if ($urandom % 8 == 0) rb = 32'hFFFF_FFFF;
            do_op(($urandom % 8) != 0, rop, $urandom % 2 == 1, $urandom % 4 == 0, ra, rb);
        end

        // Reset mid-run clears a set carry.
        do_op(1, 3'd0, 0, 0, 32'h8000_0000, 32'h8000_0000);
        @(negedge clk); rst_n = 1'b0; op_en = 1'b0;
        @(posedge clk); #2;
        model_cy = 1'b0;
        check("R10 reset clears flag", {31'd0, cy_flag}, 32'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule